// File: doc/BRIEF.md
# Memory CRC32 Scan Engine

This block works through a run of consecutive 32-bit words in memory and computes a CRC32 over them. It reads each word itself; the host only sets it up and then collects the result. Software places three values in the register port:
- the first word index;
- how many words to cover;
- a starting accumulator value, normally all ones.

Software then writes the start bit. The engine issues one read at a time on a request/response memory port and folds every returned word into the accumulator, all 32 bits in a single cycle. It stops when the last word has been folded in or when a read comes back with an error.

The accumulator register serves as the seed on the way in and as the result on the way out. It holds the raw reflected CRC, and software inverts it to obtain the conventional checksum. Completion, bus error and misuse are reported as sticky flags, which software clears by writing ones to them.

Top module: `crc_scan_engine`

## Requirements
- R1: Each returned word is folded LSB first into a reflected CRC32 with polynomial 0xEDB88320. With seed 0xFFFFFFFF and the single word 0x00000000, DATA reads 0xDEBB20E3 at the end (the complement of 0x2144DF1C).
- R2: The ADDR register holds a word index. The engine reads byte addresses ADDR×4, ADDR×4+4, and so on in ascending order, and it issues exactly LENGTH reads on an error-free run.
- R3: A write to DATA while idle loads the accumulator, and that value becomes the seed of the next run.
- R4: Writing 1 to bit 0 of CTRL while idle starts a run. CTRL bit 0 reads 1 while a run is in progress and 0 otherwise.
- R5: STATUS uses bit 0 for DONE, bit 1 for BERR and bit 2 for FAIL. DONE is set in the same clock edge that folds in the last word, and that edge also ends the run.
- R6: Writing 1 to a STATUS bit clears that bit, and writing 0 leaves it unchanged. A hardware set in the same cycle takes priority over the clear.
- R7: A read response flagged as an error sets both BERR and DONE and ends the run. No further read is issued, and DATA keeps the value it had after the last good word.
- R8: A start request while LENGTH is zero sets FAIL, issues no read and leaves the engine idle.
- R9: While a run is in progress, writes to ADDR, LENGTH and DATA are ignored, and so is a further start request.
- R10: At most one read is outstanding. A request lasts a single cycle, and no new request is issued until its response has arrived.
- R11: The register offsets are CTRL 0x00, STATUS 0x04, ADDR 0x08, LENGTH 0x0C and DATA 0x10. Any other offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response carries an error |

## Verification
The bench checks the fold against a known single-word value and against an independent bitwise model under several seeds, lengths and response latencies. A byte-indexed ADDR, a lost LSB-first order or an off-by-one count would each produce a wrong DATA value or a wrong read sequence.

It injects an error on the third word of a run. A design that kept fetching would show extra reads, and one that folded the bad word would show a changed DATA. It also starts a run with a zero length, where a design that still read memory or hung busy would be caught.

It pokes ADDR, LENGTH, DATA and CTRL during a slow run, which catches a design that lets those writes through. It also probes write-one-to-clear with zero and one masks.

// File: rtl/crc_scan_pkg.sv
`timescale 1ns/1ps
package crc_scan_pkg;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam int          REG_AW   = 5;

    localparam logic [REG_AW-1:0] OFF_CTRL   = 5'h00;
    localparam logic [REG_AW-1:0] OFF_STATUS = 5'h04;
    localparam logic [REG_AW-1:0] OFF_ADDR   = 5'h08;
    localparam logic [REG_AW-1:0] OFF_LENGTH = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_DATA   = 5'h10;

    localparam int ST_DONE = 0;
    localparam int ST_BERR = 1;
    localparam int ST_FAIL = 2;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/crc_scan_fold.sv
`timescale 1ns/1ps
module crc_scan_fold #(
    parameter logic [31:0] POLY  = 32'hEDB88320,
    parameter int          WIDTH = 32
) (
    input  logic [31:0] crc_in,
    input  logic [31:0] word_in,
    output logic [31:0] crc_out
);
    logic [31:0] stage [0:WIDTH];

    assign stage[0] = crc_in ^ word_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY)
                                        : (stage[i] >> 1);
    end

    assign crc_out = stage[WIDTH];
endmodule

// File: rtl/crc_scan_fetch.sv
`timescale 1ns/1ps
module crc_scan_fetch
    import crc_scan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-3:0] base_idx,
    input  logic [LEN_W-1:0]  count,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              word_ok,
    output logic              last_ok,
    output logic              bus_err
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        fetch_state_e     st;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] rem;
    } fetch_s;

    fetch_s fq_q, fq_d;

    always_comb begin
        fq_d    = fq_q;
        word_ok = 1'b0;
        last_ok = 1'b0;
        bus_err = 1'b0;
        case (fq_q.st)
            FS_IDLE: begin
                if (start) begin
                    fq_d.st  = FS_REQ;
                    fq_d.idx = base_idx;
                    fq_d.rem = count;
                end
            end
            FS_REQ: fq_d.st = FS_WAIT;
            FS_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_rerr) begin
                        bus_err = 1'b1;
                        fq_d.st = FS_IDLE;
                    end else begin
                        word_ok = 1'b1;
                        if (fq_q.rem == LEN_W'(1)) begin
                            last_ok = 1'b1;
                            fq_d.st = FS_IDLE;
                        end else begin
                            fq_d.idx = fq_q.idx + IDX_W'(1);
                            fq_d.rem = fq_q.rem - LEN_W'(1);
                            fq_d.st  = FS_REQ;
                        end
                    end
                end
            end
            default: fq_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fq_q <= '0;
        else        fq_q <= fq_d;
    end

    assign mem_req  = (fq_q.st == FS_REQ);
    assign busy     = (fq_q.st != FS_IDLE);
    assign mem_addr = {fq_q.idx, 2'b00};

    assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> busy);

    assert_next_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && !last_ok) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(4)));

    assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/crc_scan_engine.sv
`timescale 1ns/1ps
module crc_scan_engine
    import crc_scan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rerr
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] len;
        logic [31:0]      crc;
        logic             done;
        logic             berr;
        logic             fail;
    } regs_s;

    regs_s rq_q, rq_d;

    logic        busy, word_ok, last_ok, bus_err;
    logic        start_req, start_go;
    logic [31:0] fold_out;

    crc_scan_fold #(.POLY(CRC_POLY), .WIDTH(32)) u_fold (
        .crc_in  (rq_q.crc),
        .word_in (mem_rdata),
        .crc_out (fold_out)
    );

    crc_scan_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_go),
        .base_idx   (rq_q.idx),
        .count      (rq_q.len),
        .mem_rvalid (mem_rvalid),
        .mem_rerr   (mem_rerr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .word_ok    (word_ok),
        .last_ok    (last_ok),
        .bus_err    (bus_err)
    );

    always_comb begin
        rq_d      = rq_q;
        start_req = reg_we && (reg_addr == OFF_CTRL) && reg_wdata[0] && !busy;
        start_go  = start_req && (rq_q.len != '0);

        if (reg_we && !busy) begin
            case (reg_addr)
                OFF_ADDR:   rq_d.idx = reg_wdata[IDX_W-1:0];
                OFF_LENGTH: rq_d.len = reg_wdata[LEN_W-1:0];
                OFF_DATA:   rq_d.crc = reg_wdata;
                default:    ;
            endcase
        end
        if (word_ok) rq_d.crc = fold_out;

        if (reg_we && reg_addr == OFF_STATUS) begin
            if (reg_wdata[ST_DONE]) rq_d.done = 1'b0;
            if (reg_wdata[ST_BERR]) rq_d.berr = 1'b0;
            if (reg_wdata[ST_FAIL]) rq_d.fail = 1'b0;
        end
        if (last_ok || bus_err)            rq_d.done = 1'b1;
        if (bus_err)                       rq_d.berr = 1'b1;
        if (start_req && rq_q.len == '0)   rq_d.fail = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    always_comb begin
        case (reg_addr)
            OFF_CTRL:   reg_rdata = {31'd0, busy};
            OFF_STATUS: reg_rdata = {29'd0, rq_q.fail, rq_q.berr, rq_q.done};
            OFF_ADDR:   reg_rdata = 32'(rq_q.idx);
            OFF_LENGTH: reg_rdata = 32'(rq_q.len);
            OFF_DATA:   reg_rdata = rq_q.crc;
            default:    reg_rdata = 32'd0;
        endcase
    end

    assert_zero_len_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_CTRL && reg_wdata[0] && !busy && rq_q.len == '0)
        |=> (rq_q.fail && !busy && !mem_req));

    assert_berr_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rvalid && mem_rerr && !mem_req)
        |=> (rq_q.berr && rq_q.done && !busy && rq_q.crc == $past(rq_q.crc)));

    assert_done_with_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last_ok |=> (rq_q.done && !busy));

    assert_addr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == OFF_ADDR) |=> (rq_q.idx == $past(rq_q.idx)));

    assert_len_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == OFF_LENGTH) |=> (rq_q.len == $past(rq_q.len)));
endmodule

// File: tb/crc_scan_engine_bench.sv
`timescale 1ns/1ps
module crc_scan_engine_bench;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_ADDR = 5'h08,
                           A_LEN  = 5'h0C, A_DATA = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;

    int tests = 0, fails = 0;
    int lat_cfg = 1, nreads = 0, cnt = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0, exp_addr = '0, err_addr = '0;
    logic        err_en = 1'b0;

    always #2.5 clk = ~clk;

    crc_scan_engine u_crc_scan_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_rerr(mem_rerr)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a == 0) ? 32'd0 : ((a * 32'h9E3779B1) ^ 32'h0BADF00D);
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] seed, input int idx, input int n);
        logic [31:0] c;
        c = seed;
        for (int w = 0; w < n; w++) begin
            c = c ^ mem_word(32'((idx + w) * 4));
            for (int b = 0; b < 32; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: responds lat_cfg cycles after each request, checks ordering
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
        end
        if (pend) begin
            if (cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(pend_addr);
                mem_rerr   = err_en && (pend_addr == err_addr);
                pend       = 1'b0;
            end else cnt--;
        end
        if (rst_n && mem_req) begin
            if (pend) chk("R10 request while outstanding", 32'd1, 32'd0);
            if (mem_addr !== exp_addr) chk("R2 read address", mem_addr, exp_addr);
            pend      = 1'b1;
            pend_addr = mem_addr;
            cnt       = lat_cfg;
            exp_addr  = exp_addr + 4;
            nreads++;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(A_STAT, v);
            if (v[0]) break;
        end
    endtask

    task automatic launch(input int idx, input int len, input logic [31:0] seed, input int lat);
        wr(A_ADDR, 32'(idx));
        wr(A_LEN, 32'(len));
        wr(A_DATA, seed);
        lat_cfg  = lat;
        exp_addr = 32'(idx * 4);
        nreads   = 0;
        wr(A_CTRL, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STAT, v); chk("R5 status after reset", v, 32'd0);
        rd(A_CTRL, v); chk("R4 ctrl idle after reset", v, 32'd0);
        rd(A_DATA, v); chk("R11 data after reset", v, 32'd0);
        rd(5'h14, v);  chk("R11 unmapped offset", v, 32'd0);
    endtask

    task automatic t_known();
        logic [31:0] v;
        launch(0, 1, 32'hFFFFFFFF, 1);
        wait_done();
        rd(A_DATA, v); chk("R1 known single word", v, 32'hDEBB20E3);
        chk("R2 read count one word", 32'(nreads), 32'd1);
        rd(A_STAT, v); chk("R5 done only", v, 32'd1);
        rd(A_CTRL, v); chk("R4 ctrl clear after done", v, 32'd0);
        wr(A_STAT, 32'd7);
    endtask

    task automatic t_multi();
        logic [31:0] v;
        launch(5, 7, 32'hFFFFFFFF, 2);
        wait_done();
        rd(A_DATA, v); chk("R1 seven words", v, ref_crc(32'hFFFFFFFF, 5, 7));
        chk("R2 read count seven", 32'(nreads), 32'd7);
        rd(A_ADDR, v); chk("R2 addr register kept", v, 32'd5);
        wr(A_STAT, 32'd7);
    endtask

    task automatic t_seed();
        logic [31:0] v;
        launch(100, 3, 32'h12345678, 0);
        wait_done();
        rd(A_DATA, v); chk("R3 custom seed", v, ref_crc(32'h12345678, 100, 3));
        wr(A_STAT, 32'd7);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        launch(9, 1, 32'hFFFFFFFF, 1);
        wait_done();
        wr(A_STAT, 32'd0);
        rd(A_STAT, v); chk("R6 write zero keeps done", v, 32'd1);
        wr(A_STAT, 32'd1);
        rd(A_STAT, v); chk("R6 write one clears done", v, 32'd0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(A_LEN, 32'd0);
        nreads = 0;
        wr(A_CTRL, 32'd1);
        repeat (5) @(negedge clk);
        rd(A_STAT, v); chk("R8 fail on zero length", v, 32'd4);
        rd(A_CTRL, v); chk("R8 idle after zero start", v, 32'd0);
        chk("R8 no reads", 32'(nreads), 32'd0);
        wr(A_STAT, 32'd4);
        rd(A_STAT, v); chk("R6 fail cleared", v, 32'd0);
    endtask

    task automatic t_berr();
        logic [31:0] v;
        err_en   = 1'b1;
        err_addr = 32'(22 * 4);
        launch(20, 6, 32'hFFFFFFFF, 1);
        wait_done();
        repeat (10) @(negedge clk);
        rd(A_STAT, v); chk("R7 berr and done", v, 32'd3);
        rd(A_DATA, v); chk("R7 data holds good words", v, ref_crc(32'hFFFFFFFF, 20, 2));
        chk("R7 reads stop at error", 32'(nreads), 32'd3);
        err_en = 1'b0;
        wr(A_STAT, 32'd2);
        rd(A_STAT, v); chk("R7 berr sticky until cleared", v, 32'd1);
        wr(A_STAT, 32'd7);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        launch(40, 2, 32'hFFFFFFFF, 20);
        rd(A_CTRL, v); chk("R4 ctrl reads running", v, 32'd1);
        wr(A_ADDR, 32'h77);
        wr(A_LEN, 32'd9);
        wr(A_DATA, 32'd0);
        wr(A_CTRL, 32'd1);
        wait_done();
        repeat (30) @(negedge clk);
        rd(A_ADDR, v); chk("R9 addr write ignored", v, 32'd40);
        rd(A_LEN, v);  chk("R9 length write ignored", v, 32'd2);
        rd(A_DATA, v); chk("R9 data write ignored", v, ref_crc(32'hFFFFFFFF, 40, 2));
        chk("R9 restart ignored", 32'(nreads), 32'd2);
        wr(A_STAT, 32'd7);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_known();
        t_multi();
        t_seed();
        t_w1c();
        t_zero();
        t_berr();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule